// File: doc/BRIEF.md
# Timer Capture Channel with Edge Prescaler

This block is one channel of a general-purpose timer, set up either as an output or as an input capture. A two-bit mode field sets the direction. In input mode the same field selects the edge source: the channel's own filtered input, the filtered input of the adjacent channel, or an internal trigger strobe. The internal trigger is usable only while the timer has an internal trigger source selected, and the `trig_ok` input reports that condition.

Selected edges pass through a prescaler. A two-bit divider field sets the prescaler so that a capture happens on every 1st, 2nd, 4th or 8th selected edge. On a capture the channel copies the running counter value into its capture register and sets a sticky capture flag. If a capture arrives while that flag is still set, a second sticky flag records the overcapture. Software clears each flag with a one-cycle clear pulse. The mode field can be changed only while the channel is disabled. Disabling the channel also empties the prescaler.

Top module: `capch_channel`

## Requirements
- R1: Mode value 2'b00 makes the channel an output. `is_output` is 1, and no capture happens, whatever strobes arrive.
- R2: Mode 2'b01 takes edges from `own_edge` only, and mode 2'b10 takes edges from `nbr_edge` only. The other strobes have no effect in these modes.
- R3: Mode 2'b11 takes edges from `trg_edge` while `trig_ok` is 1.
- R4: In mode 2'b11 with `trig_ok` at 0, no capture happens.
- R5: Divider value d (0..3) gives a capture on every 2^d-th selected edge, so 1, 2, 4 or 8 edges per capture. The prescaler counts only selected edges that arrive while `chan_en` is 1. If the divider is lowered below the current count, the next selected edge captures.
- R6: While `chan_en` is 0 the prescaler count is cleared and no capture happens. After re-enabling, counting starts from zero.
- R7: A `cfg_we` pulse loads `cfg_mode` only if `chan_en` is 0. While the channel is enabled, the write leaves `mode_q` unchanged. `cfg_div` loads on every `cfg_we` pulse.
- R8: A capture copies the `cnt_val` present at the clock edge that carries the capturing strobe into `cap_val` and sets `cap_flag`. Both are visible one cycle later.
- R9: `cap_flag` clears on `clr_cap` unless a capture occurs in the same cycle. `ovr_flag` sets on a capture while `cap_flag` is already 1. Otherwise `ovr_flag` clears on `clr_ovr`.
- R10: After reset, `mode_q`=0, `div_q`=0, `is_output`=1, `cap_val`=0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode value to write |
| cfg_div | input | 2 | Divider value to write |
| trig_ok | input | 1 | An internal trigger source is selected |
| cnt_val | input | CNT_W | Running timer counter value |
| own_edge | input | 1 | Active edge strobe of the channel's own filtered input |
| nbr_edge | input | 1 | Active edge strobe of the adjacent channel's filtered input |
| trg_edge | input | 1 | Internal trigger strobe |
| clr_cap | input | 1 | Clear pulse for the capture flag |
| clr_ovr | input | 1 | Clear pulse for the overcapture flag |
| mode_q | output | 2 | Current mode |
| div_q | output | 2 | Current divider |
| is_output | output | 1 | Channel is in output direction |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. Configuration readback, the captured value and both flags all appear after that one edge, and the prescaler adds no extra latency, only edge counting. The bench drives inputs just after a falling edge. It advances a reference model at the next rising edge and compares all outputs at the following falling edge. A mismatch is therefore tied to exactly one cycle of stimulus.

// File: rtl/capch_pkg.sv
package capch_pkg;
  typedef enum logic [1:0] {
    MODE_OUT = 2'b00,
    MODE_OWN = 2'b01,
    MODE_NBR = 2'b10,
    MODE_TRG = 2'b11
  } chan_mode_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/capch_src_sel.sv
module capch_src_sel
  import capch_pkg::*;
(
  input  chan_mode_e           mode,
  input  logic                 trig_ok,
  input  logic [NUM_SRC-1:0]   edges,
  output logic                 sel_edge
);
  logic [NUM_SRC-1:0] gate;

  // one gate per source; source k serves mode k+1
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_gate
    if (k == NUM_SRC - 1) begin : g_trig
      assign gate[k] = edges[k] && (mode == chan_mode_e'(k + 1)) && trig_ok;
    end else begin : g_pin
      assign gate[k] = edges[k] && (mode == chan_mode_e'(k + 1));
    end
  end

  assign sel_edge = |gate;
endmodule

// File: rtl/capch_prescale.sv
module capch_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             edge_in,
  input  logic [DIV_W-1:0] div,
  output logic             fire
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'((32'd1 << div) - 32'd1);
  // >= so that lowering the divider mid-count still captures next edge
  assign fire  = enable && edge_in && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (edge_in) begin
      if (fire) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/capch_latch.sv
module capch_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             clr_cap,
  input  logic             clr_ovr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (fire) cap_val <= cnt_val;

      if (fire)         cap_flag <= 1'b1;
      else if (clr_cap) cap_flag <= 1'b0;

      if (fire && cap_flag) ovr_flag <= 1'b1;
      else if (clr_ovr)     ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/capch_channel.sv
module capch_channel
  import capch_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             trig_ok,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             own_edge,
  input  logic             nbr_edge,
  input  logic             trg_edge,
  input  logic             clr_cap,
  input  logic             clr_ovr,
  output logic [1:0]       mode_q,
  output logic [DIV_W-1:0] div_q,
  output logic             is_output,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag
);
  chan_mode_e         mode_r;
  logic               sel_edge;
  logic               fire;
  logic [NUM_SRC-1:0] edges;

  assign edges = {trg_edge, nbr_edge, own_edge};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r    <= MODE_OUT;
      div_q     <= '0;
      is_output <= 1'b1;
    end else if (cfg_we) begin
      div_q <= cfg_div;
      if (!chan_en) begin
        mode_r    <= chan_mode_e'(cfg_mode);
        is_output <= (cfg_mode == MODE_OUT);
      end
    end
  end

  assign mode_q = mode_r;

  capch_src_sel i_src (
    .mode     (mode_r),
    .trig_ok  (trig_ok),
    .edges    (edges),
    .sel_edge (sel_edge)
  );

  capch_prescale #(.DIV_W(DIV_W)) i_pre (
    .clk     (clk),
    .rst     (rst),
    .enable  (chan_en),
    .edge_in (sel_edge),
    .div     (div_q),
    .fire    (fire)
  );

  capch_latch #(.CNT_W(CNT_W)) i_lat (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .cnt_val  (cnt_val),
    .clr_cap  (clr_cap),
    .clr_ovr  (clr_ovr),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .ovr_flag (ovr_flag)
  );
endmodule

// File: rtl/capch_checker.sv
module capch_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             trig_ok,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             ovr_flag
);
  assert_out_no_cap_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |=> ($stable(cap_val) && !$rose(cap_flag)));

  assert_no_trig_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11 && !trig_ok) |=> ($stable(cap_val) && !$rose(cap_flag)));

  assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> ($stable(cap_val) && !$rose(cap_flag)));

  assert_mode_lock_R7: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> $stable(mode_q));

  assert_flag_on_cap_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_val) |-> cap_flag);

  assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(cap_flag));
endmodule

bind capch_channel capch_checker #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .chan_en  (chan_en),
  .trig_ok  (trig_ok),
  .mode_q   (mode_q),
  .cap_val  (cap_val),
  .cap_flag (cap_flag),
  .ovr_flag (ovr_flag)
);

// File: tb/test_capch_channel.sv
module test_capch_channel;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 0, cfg_we = 0, trig_ok = 0;
  logic [1:0] cfg_mode = 0, cfg_div = 0;
  logic [CNT_W-1:0] cnt_val = 0;
  logic own_edge = 0, nbr_edge = 0, trg_edge = 0, clr_cap = 0, clr_ovr = 0;
  logic [1:0] mode_q, div_q;
  logic is_output, cap_flag, ovr_flag;
  logic [CNT_W-1:0] cap_val;

  int total = 0, bad = 0;
  int m_mode = 0, m_div = 0, m_pc = 0, m_cap = 0, m_f = 0, m_o = 0;

  always #10 clk = ~clk;

  capch_channel #(.CNT_W(CNT_W), .DIV_W(2)) i_capch_channel (
    .clk(clk), .rst(rst), .chan_en(chan_en), .cfg_we(cfg_we),
    .cfg_mode(cfg_mode), .cfg_div(cfg_div), .trig_ok(trig_ok),
    .cnt_val(cnt_val), .own_edge(own_edge), .nbr_edge(nbr_edge),
    .trg_edge(trg_edge), .clr_cap(clr_cap), .clr_ovr(clr_ovr),
    .mode_q(mode_q), .div_q(div_q), .is_output(is_output),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
  );

  function automatic int sel_edge_f();
    case (m_mode)
      1: return int'(own_edge);
      2: return int'(nbr_edge);
      3: return int'(trg_edge && trig_ok);
      default: return 0;
    endcase
  endfunction

  function automatic void model_step();
    int fire = 0;
    if (!chan_en) m_pc = 0;
    else if (sel_edge_f() != 0) begin
      if (m_pc >= (1 << m_div) - 1) begin fire = 1; m_pc = 0; end
      else m_pc++;
    end
    if (fire != 0 && m_f != 0) m_o = 1;
    else if (clr_ovr) m_o = 0;
    if (fire != 0) begin m_f = 1; m_cap = int'(cnt_val); end
    else if (clr_cap) m_f = 0;
    if (cfg_we) begin
      if (!chan_en) m_mode = int'(cfg_mode);
      m_div = int'(cfg_div);
    end
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "mode_q", int'(mode_q), m_mode);
    chk(tag, "div_q", int'(div_q), m_div);
    chk(tag, "is_output", int'(is_output), int'(m_mode == 0));
    chk(tag, "cap_val", int'(cap_val), m_cap);
    chk(tag, "cap_flag", int'(cap_flag), m_f);
    chk(tag, "ovr_flag", int'(ovr_flag), m_o);
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
    cfg_we = 0; own_edge = 0; nbr_edge = 0; trg_edge = 0;
    clr_cap = 0; clr_ovr = 0;
    cnt_val = CNT_W'($urandom);
  endtask

  task automatic configure(input int md, input int dv, input string tag);
    chan_en = 0; cfg_we = 1; cfg_mode = 2'(md); cfg_div = 2'(dv);
    step(tag);
    chan_en = 1;
  endtask

  task automatic pulse(input int which, input string tag);
    own_edge = (which == 0); nbr_edge = (which == 1); trg_edge = (which == 2);
    step(tag);
  endtask

  task automatic clear_flags(input string tag);
    clr_cap = 1; clr_ovr = 1; step(tag);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step("R10 reset");
    @(negedge clk);
    rst = 0;
    check_all("R10 reset state");

    // R1: output mode ignores all strobes
    chan_en = 1;
    for (int i = 0; i < 3; i++) pulse(i, "R1 output mode");

    // R2: own and neighbour source selection
    configure(1, 0, "R2 cfg own");
    pulse(1, "R2 nbr ignored in own mode");
    pulse(2, "R2 trg ignored in own mode");
    pulse(0, "R2 own capture");
    pulse(0, "R9 overcapture");
    clear_flags("R9 clear");
    configure(2, 0, "R2 cfg nbr");
    pulse(0, "R2 own ignored in nbr mode");
    pulse(1, "R2 nbr capture");

    // R3 / R4: trigger source
    configure(3, 0, "R3 cfg trig");
    trig_ok = 0;
    pulse(2, "R4 trigger absent");
    trig_ok = 1;
    pulse(2, "R3 trigger capture");

    // R5: every divider value
    for (int d = 0; d < 4; d++) begin
      configure(1, d, "R5 cfg div");
      clear_flags("R9 clear");
      for (int e = 0; e < 9; e++) pulse(0, "R5 divider");
    end
    // R5: lower divider mid-count
    configure(1, 3, "R5 cfg");
    for (int e = 0; e < 5; e++) pulse(0, "R5 partial count");
    cfg_we = 1; cfg_div = 2'd0; step("R5 lower divider");
    pulse(0, "R5 capture after lowering");

    // R6: disable clears prescaler
    configure(1, 1, "R6 cfg");
    pulse(0, "R6 first half");
    chan_en = 0; own_edge = 1; step("R6 disabled edge");
    chan_en = 1;
    pulse(0, "R6 restart count");
    pulse(0, "R6 capture after restart");

    // R7: mode lock while enabled
    cfg_we = 1; cfg_mode = 2'd0; cfg_div = 2'd2; step("R7 write while enabled");
    pulse(0, "R7 still capturing");

    // R9: capture beats clear in same cycle
    configure(1, 0, "R9 cfg");
    clr_cap = 1; own_edge = 1; step("R9 capture wins clear");
    clr_cap = 1; step("R9 plain clear");

    // R8 random mix
    for (int n = 0; n < 4000; n++) begin
      chan_en = ($urandom_range(0, 15) != 0);
      cfg_we = ($urandom_range(0, 19) == 0);
      cfg_mode = 2'($urandom); cfg_div = 2'($urandom);
      trig_ok = ($urandom_range(0, 3) != 0);
      own_edge = ($urandom_range(0, 2) == 0);
      nbr_edge = ($urandom_range(0, 2) == 0);
      trg_edge = ($urandom_range(0, 2) == 0);
      clr_cap = ($urandom_range(0, 5) == 0);
      clr_ovr = ($urandom_range(0, 7) == 0);
      step("R8 random capture value");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule